// File: doc/BRIEF.md
# Descriptor-Driven Crypto Channel Sequencer

This block is the control engine of one channel in a bus-mastering crypto coprocessor. The host hands it a job by writing the address of an eight-word descriptor into the channel's fetch register. That single write is the whole launch. From there the channel runs the job on its own:

1. It reads the descriptor over a 32-bit master port.
2. It decodes the operation code and the unit type.
3. It asks a controller for an execution unit and waits for the grant.
4. It streams the key, then the context/IV, then the input data into the unit.
5. It writes each result word back to memory.

The execution unit here is a stand-in. It absorbs key and IV words. It passes each data word unchanged to a small output FIFO after a fixed pipeline delay.

Completion, bus errors and refused fetch writes are recorded in sticky status bits. A level interrupt is raised while the done or error bit is set. The host clears the status with a one-cycle clear strobe.

Descriptor layout (byte offsets from the descriptor address, each word 32 bits):

| Offset | Content |
|---|---|
| +0x00 | Header: op code in bits [7:0], unit type in bits [11:8] |
| +0x04 | Key length in words |
| +0x08 | Key pointer |
| +0x0C | IV length in words |
| +0x10 | IV pointer |
| +0x14 | Input length in words |
| +0x18 | Input pointer |
| +0x1C | Output pointer |

Top module: `chan_seq`

## Requirements
- R1: A fetch write while the channel is idle starts a job: status bit 0 (busy) reads 1 from the next cycle. The channel then reads eight descriptor words at ascending addresses. The first address is the fetch pointer with bits [1:0] forced to 0.
- R2: The op code (header bits [7:0]) and unit type (header bits [11:8]) from the descriptor appear on eu_op_o and eu_type_o while the unit request is raised.
- R3: After the last descriptor word the channel raises eu_req_o and holds it until eu_gnt_i. No master transfer occurs while eu_req_o is high, and no operand is read before the grant.
- R4: Operands are read in a fixed order: key words, then IV words, then input words. Each group is read at ascending addresses from its pointer, and a group of length zero is skipped.
- R5: After each input word is read, its result is written to output pointer + 4·i. This write happens before the next input word is read. The written value equals the input word.
- R6: A master request keeps its address, direction and write data stable until mst_ack_i or mst_err_i is seen.
- R7: At the end of a job the channel pulses eu_rel_o for one cycle, sets status bit 1 (done), clears busy, and holds irq_o high.
- R8: A fetch write while busy is ignored: the running job's transfers are unchanged. It sets status bit 3 (overrun), which stays set until cleared.
- R9: mst_err_i on any transfer ends the job with no further master transfer. It releases the unit if one was granted, sets status bit 2 (error) without setting done, and raises irq_o.
- R10: stat_clr_i clears the done, error and overrun bits, and irq_o falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_we_i | input | 1 | Write strobe for the fetch register |
| fetch_ptr_i | input | 32 | Descriptor address |
| stat_clr_i | input | 1 | Clears the sticky status bits |
| status_o | output | 4 | {overrun, error, done, busy} |
| irq_o | output | 1 | Level interrupt: done or error |
| mst_req_o | output | 1 | Master transfer request |
| mst_we_o | output | 1 | 1 = write, 0 = read |
| mst_addr_o | output | 32 | Byte address, word aligned |
| mst_wdata_o | output | 32 | Write data |
| mst_rdata_i | input | 32 | Read data, valid with ack |
| mst_ack_i | input | 1 | Transfer completed |
| mst_err_i | input | 1 | Transfer failed |
| eu_req_o | output | 1 | Execution unit request |
| eu_type_o | output | 4 | Requested unit type |
| eu_op_o | output | 8 | Decoded op code |
| eu_gnt_i | input | 1 | Unit granted |
| eu_rel_o | output | 1 | Unit release pulse |

## Verification
Busy and overrun appear one cycle after the fetch write's sampling edge. The bench drives inputs on falling edges and reads status on the next falling edge.

The master model answers each request at the falling edge after it appears, with a one-cycle response. It logs each transfer once. The bench compares the whole ordered log rather than guessing cycle counts, because the data path adds the unit's pipeline delay before each write-back.

Done, error and irq_o are due one cycle after the release or abort edge. The bench polls busy on falling edges and checks these bits once busy has fallen. irq_o is checked again one cycle after the clear strobe.

// File: rtl/ch_pkg.sv
package ch_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_OVR  = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC, S_EUREQ, S_PHASE, S_RD, S_WAIT, S_WB, S_REL
  } state_e;

  typedef enum logic [1:0] {PH_KEY, PH_IV, PH_DATA} phase_e;

  typedef struct packed {
    logic [7:0]        op;
    logic [3:0]        eu_type;
    logic [WORD_W-1:0] key_len;
    logic [WORD_W-1:0] key_ptr;
    logic [WORD_W-1:0] iv_len;
    logic [WORD_W-1:0] iv_ptr;
    logic [WORD_W-1:0] in_len;
    logic [WORD_W-1:0] in_ptr;
    logic [WORD_W-1:0] out_ptr;
  } desc_t;
endpackage

// File: rtl/ch_desc_store.sv
module ch_desc_store
  import ch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] data_i,
  output desc_t             desc_o
);
  logic [11:0]       hdr_q;
  logic [WORD_W-1:0] w_q [1:DESC_WORDS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hdr_q <= '0;
    else if (wr_i && idx_i == '0)      hdr_q <= data_i[11:0];
  end

  for (genvar g = 1; g < DESC_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            w_q[g] <= '0;
      else if (wr_i && idx_i == IDX_W'(g))    w_q[g] <= data_i;
    end
  end

  always_comb begin
    desc_o.op      = hdr_q[7:0];
    desc_o.eu_type = hdr_q[11:8];
    desc_o.key_len = w_q[1];
    desc_o.key_ptr = w_q[2];
    desc_o.iv_len  = w_q[3];
    desc_o.iv_ptr  = w_q[4];
    desc_o.in_len  = w_q[5];
    desc_o.in_ptr  = w_q[6];
    desc_o.out_ptr = w_q[7];
  end
endmodule

// File: rtl/ch_fifo.sv
module ch_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;
  logic          do_push, do_pop;

  assign do_push = push_i && (cnt_q < (PW+1)'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(do_push) - (PW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/ch_eu_stub.sv
module ch_eu_stub
  import ch_pkg::*;
#(
  parameter int LATENCY = 3,
  parameter int DEPTH   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  phase_e            kind_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              pop_i,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o
);
  logic [LATENCY-1:0] v_q;
  logic [WORD_W-1:0]  d_q [LATENCY];

  // key and IV words are consumed; only data flows to the output side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0] <= 1'b0;
      d_q[0] <= '0;
    end else begin
      v_q[0] <= !flush_i && push_i && (kind_i == PH_DATA);
      d_q[0] <= data_i;
    end
  end

  for (genvar g = 1; g < LATENCY; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[g] <= 1'b0;
        d_q[g] <= '0;
      end else begin
        v_q[g] <= !flush_i && v_q[g-1];
        d_q[g] <= d_q[g-1];
      end
    end
  end

  ch_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_out_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (v_q[LATENCY-1] && !flush_i),
    .data_i  (d_q[LATENCY-1]),
    .pop_i   (pop_i),
    .valid_o (out_valid_o),
    .data_o  (out_data_o)
  );
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import ch_pkg::*;
#(
  parameter int EU_LATENCY = 3,
  parameter int OUT_DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_we_i,
  input  logic [WORD_W-1:0] fetch_ptr_i,
  input  logic              stat_clr_i,
  output logic [3:0]        status_o,
  output logic              irq_o,
  output logic              mst_req_o,
  output logic              mst_we_o,
  output logic [WORD_W-1:0] mst_addr_o,
  output logic [WORD_W-1:0] mst_wdata_o,
  input  logic [WORD_W-1:0] mst_rdata_i,
  input  logic              mst_ack_i,
  input  logic              mst_err_i,
  output logic              eu_req_o,
  output logic [3:0]        eu_type_o,
  output logic [7:0]        eu_op_o,
  input  logic              eu_gnt_i,
  output logic              eu_rel_o
);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  state_e             state_q;
  phase_e             phase_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WORD_W-1:0]  addr_q, wb_q, cnt_q;
  logic               held_q, abort_q, done_q, err_q, ovr_q;
  desc_t              desc;
  logic               xfer_ok, xfer_err, busy;
  logic               out_valid;
  logic [WORD_W-1:0]  out_data;

  assign busy      = (state_q != S_IDLE);
  assign mst_req_o = (state_q == S_DESC) || (state_q == S_RD) || (state_q == S_WB);
  assign mst_we_o  = (state_q == S_WB);
  assign mst_addr_o  = (state_q == S_WB) ? wb_q : addr_q;
  assign mst_wdata_o = out_data;
  assign xfer_ok   = mst_req_o && mst_ack_i && !mst_err_i;
  assign xfer_err  = mst_req_o && mst_err_i;

  assign eu_req_o  = (state_q == S_EUREQ);
  assign eu_type_o = desc.eu_type;
  assign eu_op_o   = desc.op;
  assign eu_rel_o  = (state_q == S_REL);

  assign status_o = {ovr_q, err_q, done_q, busy};
  assign irq_o    = done_q | err_q;

  ch_desc_store u_desc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (xfer_ok && state_q == S_DESC),
    .idx_i  (idx_q),
    .data_i (mst_rdata_i),
    .desc_o (desc)
  );

  ch_eu_stub #(.LATENCY(EU_LATENCY), .DEPTH(OUT_DEPTH)) u_eu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (state_q == S_REL),
    .push_i      (xfer_ok && state_q == S_RD),
    .kind_i      (phase_q),
    .data_i      (mst_rdata_i),
    .pop_i       (xfer_ok && state_q == S_WB),
    .out_valid_o (out_valid),
    .out_data_o  (out_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      phase_q <= PH_KEY;
      idx_q   <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      cnt_q   <= '0;
      held_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (xfer_err) begin
        abort_q <= 1'b1;
        state_q <= held_q ? S_REL : S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: if (fetch_we_i) begin
            addr_q  <= fetch_ptr_i & ~WORD_W'(3);
            idx_q   <= '0;
            abort_q <= 1'b0;
            state_q <= S_DESC;
          end
          S_DESC: if (xfer_ok) begin
            addr_q <= addr_q + STEP;
            idx_q  <= idx_q + 1'b1;
            if (idx_q == IDX_W'(DESC_WORDS-1)) state_q <= S_EUREQ;
          end
          S_EUREQ: if (eu_gnt_i) begin
            held_q  <= 1'b1;
            phase_q <= PH_KEY;
            cnt_q   <= desc.key_len;
            addr_q  <= desc.key_ptr;
            wb_q    <= desc.out_ptr;
            state_q <= S_PHASE;
          end
          S_PHASE: begin
            if (cnt_q != '0) begin
              state_q <= S_RD;
            end else begin
              unique case (phase_q)
                PH_KEY: begin
                  phase_q <= PH_IV;
                  cnt_q   <= desc.iv_len;
                  addr_q  <= desc.iv_ptr;
                end
                PH_IV: begin
                  phase_q <= PH_DATA;
                  cnt_q   <= desc.in_len;
                  addr_q  <= desc.in_ptr;
                end
                default: state_q <= S_REL;
              endcase
            end
          end
          S_RD: if (xfer_ok) begin
            cnt_q   <= cnt_q - 1'b1;
            addr_q  <= addr_q + STEP;
            state_q <= (phase_q == PH_DATA) ? S_WAIT : S_PHASE;
          end
          S_WAIT: if (out_valid) state_q <= S_WB;
          S_WB: if (xfer_ok) begin
            wb_q    <= wb_q + STEP;
            state_q <= S_PHASE;
          end
          S_REL: begin
            held_q  <= 1'b0;
            state_q <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  // sticky status: a set in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (stat_clr_i) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (fetch_we_i && busy)                  ovr_q  <= 1'b1;
      if (xfer_err)                            err_q  <= 1'b1;
      if (state_q == S_REL && !abort_q)        done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fetch_we_i,
  input logic        stat_clr_i,
  input logic [3:0]  status_o,
  input logic        mst_req_o,
  input logic        mst_we_o,
  input logic [31:0] mst_addr_o,
  input logic [31:0] mst_wdata_o,
  input logic        mst_ack_i,
  input logic        mst_err_i,
  input logic        eu_req_o,
  input logic        eu_gnt_i,
  input logic        eu_rel_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && !mst_ack_i && !mst_err_i |=> mst_req_o && $stable(mst_addr_o) && $stable(mst_we_o)); // R6
  AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && mst_we_o && !mst_ack_i && !mst_err_i |=> $stable(mst_wdata_o)); // R6
  AST_EU_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eu_req_o && !eu_gnt_i |=> eu_req_o); // R3
  AST_NO_XFER_WHILE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eu_req_o |-> !mst_req_o); // R3
  AST_ERR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && mst_err_i |=> !mst_req_o); // R9
  AST_REL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eu_rel_o |=> !status_o[0] && !eu_rel_o); // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] && !stat_clr_i |=> status_o[3]); // R8
  AST_CLR_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i && !fetch_we_i |=> !status_o[3]); // R10
endmodule

bind chan_seq chan_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_we_i  (fetch_we_i),
  .stat_clr_i  (stat_clr_i),
  .status_o    (status_o),
  .mst_req_o   (mst_req_o),
  .mst_we_o    (mst_we_o),
  .mst_addr_o  (mst_addr_o),
  .mst_wdata_o (mst_wdata_o),
  .mst_ack_i   (mst_ack_i),
  .mst_err_i   (mst_err_i),
  .eu_req_o    (eu_req_o),
  .eu_gnt_i    (eu_gnt_i),
  .eu_rel_o    (eu_rel_o)
);

// File: tb/tb_chan_seq.sv
module tb_chan_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_we_i = 1'b0;
  logic [31:0] fetch_ptr_i = '0;
  logic        stat_clr_i = 1'b0;
  logic [3:0]  status_o;
  logic        irq_o;
  logic        mst_req_o, mst_we_o;
  logic [31:0] mst_addr_o, mst_wdata_o;
  logic [31:0] mst_rdata_i = '0;
  logic        mst_ack_i = 1'b0;
  logic        mst_err_i = 1'b0;
  logic        eu_req_o;
  logic [3:0]  eu_type_o;
  logic [7:0]  eu_op_o;
  logic        eu_gnt_i = 1'b0;
  logic        eu_rel_o;

  always #5 clk = ~clk;

  chan_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_we_i(fetch_we_i), .fetch_ptr_i(fetch_ptr_i),
    .stat_clr_i(stat_clr_i), .status_o(status_o), .irq_o(irq_o),
    .mst_req_o(mst_req_o), .mst_we_o(mst_we_o), .mst_addr_o(mst_addr_o),
    .mst_wdata_o(mst_wdata_o), .mst_rdata_i(mst_rdata_i), .mst_ack_i(mst_ack_i),
    .mst_err_i(mst_err_i), .eu_req_o(eu_req_o), .eu_type_o(eu_type_o), .eu_op_o(eu_op_o),
    .eu_gnt_i(eu_gnt_i), .eu_rel_o(eu_rel_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] log_addr [0:63];
  logic        log_we   [0:63];
  int          log_n = 0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  int          gnt_delay = 4;
  int          rel_cnt = 0, req_cyc = 0, clash = 0;
  logic [3:0]  seen_type = '0;
  logic [7:0]  seen_op = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mst_ack_i || mst_err_i) begin
        mst_ack_i = 1'b0; mst_err_i = 1'b0;
      end else if (mst_req_o && rst_ni) begin
        if (log_n < 64) begin
          log_addr[log_n] = mst_addr_o; log_we[log_n] = mst_we_o;
        end
        log_n++;
        if (mst_addr_o == err_addr) mst_err_i = 1'b1;
        else begin
          mst_ack_i = 1'b1;
          if (mst_we_o) mem[mst_addr_o[11:2]] = mst_wdata_o;
          else          mst_rdata_i = mem[mst_addr_o[11:2]];
        end
      end
    end
  end

  // unit controller and monitors
  initial begin
    int wait_c = 0;
    forever begin
      @(negedge clk);
      if (eu_rel_o) rel_cnt++;
      if (eu_req_o) begin
        req_cyc++; seen_type = eu_type_o; seen_op = eu_op_o;
        if (mst_req_o) clash++;
      end
      if (eu_gnt_i) eu_gnt_i = 1'b0;
      else if (eu_req_o) begin
        wait_c++;
        if (wait_c >= gnt_delay) begin eu_gnt_i = 1'b1; wait_c = 0; end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic clr_log();
    log_n = 0; rel_cnt = 0; req_cyc = 0; clash = 0; err_addr = 32'hFFFF_FFF0;
  endtask

  task automatic put_desc(input int base, input logic [31:0] hdr,
                          input int kl, input int kp, input int il, input int ip,
                          input int nl, input int np, input int op);
    mem[(base>>2)+0] = hdr; mem[(base>>2)+1] = kl; mem[(base>>2)+2] = kp;
    mem[(base>>2)+3] = il;  mem[(base>>2)+4] = ip; mem[(base>>2)+5] = nl;
    mem[(base>>2)+6] = np;  mem[(base>>2)+7] = op;
  endtask

  task automatic start(input logic [31:0] ptr);
    @(negedge clk); fetch_we_i = 1'b1; fetch_ptr_i = ptr;
    @(negedge clk); fetch_we_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!status_o[0]) break;
    end
    chk("R7 job ends", {31'd0, status_o[0]}, 32'd0);
  endtask

  task automatic clear_status();
    @(negedge clk); stat_clr_i = 1'b1;
    @(negedge clk); stat_clr_i = 1'b0;
    chk("R10 status cleared", {28'd0, status_o}, 32'd0);
    chk("R10 irq low", {31'd0, irq_o}, 32'd0);
  endtask

  function automatic logic [31:0] exp_addr(input int i);
    int seq [17] = '{'h100,'h104,'h108,'h10C,'h110,'h114,'h118,'h11C,
                     'h200,'h204,'h240,'h280,'h300,'h284,'h304,'h288,'h308};
    return seq[i];
  endfunction

  task automatic t_reset();
    chk("R1 reset status", {28'd0, status_o}, 32'd0);
    chk("R7 reset irq", {31'd0, irq_o}, 32'd0);
    chk("R6 reset req", {31'd0, mst_req_o}, 32'd0);
    chk("R3 reset eu_req", {31'd0, eu_req_o}, 32'd0);
  endtask

  task automatic t_normal();
    clr_log(); gnt_delay = 6;
    for (int i = 0; i < 3; i++) mem[('h300>>2)+i] = '0;
    start(32'h102);
    chk("R1 busy after fetch", {31'd0, status_o[0]}, 32'd1);
    wait_idle();
    chk("R1/R4/R5 transfer count", log_n, 17);
    for (int i = 0; i < 17; i++) begin
      chk("R4 R5 transfer address", log_addr[i], exp_addr(i));
      chk("R5 transfer direction", {31'd0, log_we[i]}, (i == 12 || i == 14 || i == 16) ? 32'd1 : 32'd0);
    end
    for (int i = 0; i < 3; i++)
      chk("R5 result data", mem[('h300>>2)+i], 32'hC0DE_0000 + i);
    chk("R2 unit type", {28'd0, seen_type}, 32'h3);
    chk("R2 op code", {24'd0, seen_op}, 32'h5A);
    chk("R3 request waited", (req_cyc >= 6) ? 32'd1 : 32'd0, 32'd1);
    chk("R3 no transfer during request", clash, 0);
    chk("R7 one release", rel_cnt, 1);
    chk("R7 done status", {28'd0, status_o}, 32'b0010);
    chk("R7 irq high", {31'd0, irq_o}, 32'd1);
    clear_status();
  endtask

  task automatic t_overrun();
    clr_log(); gnt_delay = 2;
    start(32'h100);
    repeat (2) @(negedge clk);
    fetch_we_i = 1'b1; fetch_ptr_i = 32'h400;
    @(negedge clk); fetch_we_i = 1'b0;
    chk("R8 overrun set", {31'd0, status_o[3]}, 32'd1);
    wait_idle();
    chk("R8 job unchanged count", log_n, 17);
    chk("R8 first address", log_addr[0], 32'h100);
    chk("R8 last address", log_addr[16], 32'h308);
    chk("R8 overrun kept with done", {28'd0, status_o}, 32'b1010);
    clear_status();
  endtask

  task automatic t_zero();
    clr_log();
    start(32'h140);
    wait_idle();
    chk("R4 zero lengths only descriptor", log_n, 8);
    chk("R4 last descriptor word", log_addr[7], 32'h15C);
    chk("R7 zero job done", {28'd0, status_o}, 32'b0010);
    chk("R7 zero job release", rel_cnt, 1);
    clear_status();
  endtask

  task automatic t_err_data();
    clr_log(); err_addr = 32'h284;
    start(32'h100);
    wait_idle();
    chk("R9 stops at failing read", log_n, 14);
    chk("R9 failing address", log_addr[13], 32'h284);
    chk("R9 error not done", {28'd0, status_o}, 32'b0100);
    chk("R9 irq", {31'd0, irq_o}, 32'd1);
    chk("R9 unit released", rel_cnt, 1);
    repeat (5) @(negedge clk);
    chk("R9 no later transfer", log_n, 14);
    clear_status();
  endtask

  task automatic t_err_desc();
    clr_log(); err_addr = 32'h108;
    start(32'h100);
    wait_idle();
    chk("R9 descriptor error count", log_n, 3);
    chk("R9 no unit request", req_cyc, 0);
    chk("R9 no release without grant", rel_cnt, 0);
    chk("R9 error bit", {28'd0, status_o}, 32'b0100);
    clear_status();
  endtask

  initial begin
    put_desc('h100, 32'hFFFF_F35A, 2, 'h200, 1, 'h240, 3, 'h280, 'h300);
    put_desc('h140, 32'h0000_0101, 0, 'h200, 0, 'h240, 0, 'h280, 'h380);
    mem['h200>>2] = 32'hAAAA_0001; mem['h204>>2] = 32'hAAAA_0002;
    mem['h240>>2] = 32'hBBBB_0001;
    for (int i = 0; i < 3; i++) mem[('h280>>2)+i] = 32'hC0DE_0000 + i;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_normal();
    t_overrun();
    t_zero();
    t_err_data();
    t_err_desc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule